// File: doc/BRIEF.md
# Byte absolute-difference accumulator

This unit compares two 32-bit words as four independent unsigned bytes. For every byte position it takes the magnitude of the difference between the two operands. It then adds the four magnitudes into one result, zero-extended to 32 bits. When the accumulate control is set, a third 32-bit operand is added to that total. This gives one step of a sum-of-absolute-differences metric, as used in motion search or template matching. The caller chains successive steps through the third operand.

Operands enter through a valid/ready handshake, and results leave through another one. The default build has two register stages. The first stage holds the four per-byte magnitudes together with the addend and the mode bit. The second stage holds the reduced and optionally accumulated word. A one-stage build does all of the arithmetic in front of a single output register. A stall at the output holds both stages without losing, duplicating or reordering any result.

Top module: `bsad_accum`

## Requirements
- R1: Byte lane i is bits [8i+7:8i] of each operand, taken as unsigned, and contributes |in_a lane − in_b lane| to the total, whichever operand is larger.
- R2: The result is the sum of the four lane magnitudes, zero-extended to 32 bits. For example, 0x87858381 against 0x08060402 gives 0x000001FC, and 0xFFFFFFFF against 0x00000000 gives 0x000003FC.
- R3: With in_acc_en = 1, the 32-bit in_addend is added to the sum. For example, an addend of 0x00008000 turns 0x000001FC into 0x000081FC.
- R4: With in_acc_en = 0, in_addend has no effect on the result, and result bits [31:10] are zero.
- R5: The accumulate addition wraps modulo 2^32 with no indication. For example, 0xFFFFFFFF plus 0x1FC gives 0x000001FB.
- R6: With out_ready held high, a word accepted on a clock edge (in_valid and in_ready both high) appears with out_valid exactly PIPE_DEPTH edges later. PIPE_DEPTH defaults to 2.
- R7: While out_valid is high and out_ready is low, out_valid and out_result stay unchanged. Every accepted word is delivered exactly once, in order of acceptance.
- R8: When every stage holds a word and out_ready is low, in_ready is low, and a word presented then is not taken.
- R9: After synchronous reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on the input are valid |
| in_ready | output | 1 | Unit can take operands this cycle |
| in_a | input | 32 | First operand, four unsigned bytes |
| in_b | input | 32 | Second operand, four unsigned bytes |
| in_addend | input | 32 | Third operand for accumulate mode |
| in_acc_en | input | 1 | 1 adds in_addend to the sum |
| out_valid | output | 1 | out_result holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Registered result word |

## Verification
The bench sweeps every value of one byte against a spread of values in the other operand, across all four lanes. This catches a design that takes the difference in one direction only, which would wrap to large values when the second byte is larger. It also catches a lane whose slice is mis-placed. Directed cases check the all-ones-against-zero maximum, a nonzero addend with accumulation switched off (a design that leaks it would show high bits), and an addend near 2^32, where a wrong width would clip or saturate instead of wrapping. An irregular out_ready pattern, plus a long full stall with a third word waiting, exposes dropped, duplicated or reordered results and data that changes while held. A fixed latency check catches a stage that has been bypassed or added.

// File: rtl/bsad_pkg.sv
`timescale 1ns/1ps
package bsad_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;
    localparam int SUM_W  = LANE_W + $clog2(LANES);

    typedef logic [LANE_W-1:0]             lane_t;
    typedef logic [LANES-1:0][LANE_W-1:0]  lanes_t;
    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [SUM_W-1:0]              sum_t;

    // Contents of the first pipeline register.
    typedef struct packed {
        lanes_t diffs;
        word_t  addend;
        logic   acc_en;
    } diff_stage_t;

    // Unsigned magnitude of the difference between two bytes.
    function automatic lane_t lane_absdiff(input lane_t x, input lane_t y);
        lane_t r;
        if (x >= y) r = x - y;
        else        r = y - x;
        return r;
    endfunction

    function automatic sum_t lane_widen(input lane_t x);
        return sum_t'(x);
    endfunction

endpackage

// File: rtl/bsad_lane_diff.sv
`timescale 1ns/1ps
module bsad_lane_diff
    import bsad_pkg::*;
(
    input  word_t  op_a,
    input  word_t  op_b,
    output lanes_t diffs
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign diffs[g] = lane_absdiff(op_a[g*LANE_W +: LANE_W],
                                       op_b[g*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/bsad_reduce.sv
`timescale 1ns/1ps
module bsad_reduce
    import bsad_pkg::*;
(
    input  lanes_t diffs,
    input  word_t  addend,
    input  logic   acc_en,
    output word_t  result
);

    sum_t total;

    always_comb begin
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            total = total + lane_widen(diffs[i]);
        end
    end

    // Modulo 2^WORD_W addition; the carry out is dropped on purpose.
    always_comb begin
        if (acc_en) result = addend + word_t'(total);
        else        result = word_t'(total);
    end

endmodule

// File: rtl/bsad_hold_reg.sv
`timescale 1ns/1ps
module bsad_hold_reg #(
    parameter type T = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  T     in_data,
    output logic out_valid,
    input  logic out_ready,
    output T     out_data
);

    logic v_q;
    T     d_q;

    assign in_ready  = !v_q || out_ready;
    assign out_valid = v_q;
    assign out_data  = d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else if (in_ready) begin
            v_q <= in_valid;
            if (in_valid) d_q <= in_data;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/bsad_accum.sv
`timescale 1ns/1ps
module bsad_accum
    import bsad_pkg::*;
#(
    parameter int PIPE_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_addend,
    input  logic              in_acc_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_result
);

    lanes_t lane_d;

    bsad_lane_diff u_diff (
        .op_a  (in_a),
        .op_b  (in_b),
        .diffs (lane_d)
    );

    if (PIPE_DEPTH == 2) begin : g_two_stage
        diff_stage_t s1_in;
        diff_stage_t s1_q;
        logic        s1_valid;
        logic        s2_ready;
        word_t       red;

        assign s1_in = '{diffs: lane_d, addend: in_addend, acc_en: in_acc_en};

        bsad_hold_reg #(.T(diff_stage_t)) u_s1 (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (s1_in),
            .out_valid (s1_valid),
            .out_ready (s2_ready),
            .out_data  (s1_q)
        );

        bsad_reduce u_red (
            .diffs  (s1_q.diffs),
            .addend (s1_q.addend),
            .acc_en (s1_q.acc_en),
            .result (red)
        );

        bsad_hold_reg #(.T(word_t)) u_s2 (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (s1_valid),
            .in_ready  (s2_ready),
            .in_data   (red),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (out_result)
        );

        // R6
        advance_chk: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && s2_ready) |=> out_valid);

        // R8
        full_block_chk: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && out_valid && !out_ready) |-> !in_ready);
    end else begin : g_one_stage
        word_t red;

        bsad_reduce u_red (
            .diffs  (lane_d),
            .addend (in_addend),
            .acc_en (in_acc_en),
            .result (red)
        );

        bsad_hold_reg #(.T(word_t)) u_s1 (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_ready  (in_ready),
            .in_data   (red),
            .out_valid (out_valid),
            .out_ready (out_ready),
            .out_data  (out_result)
        );

        // R6
        advance_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> out_valid);
    end

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: tb/bsad_accum_bench.sv
`timescale 1ns/1ps
module bsad_accum_bench;

    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] in_addend = '0;
    logic        in_acc_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_mode = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        hold_v = 1'b0;
    logic [31:0] hold_d = '0;

    always #10 clk = ~clk;

    bsad_accum #(.PIPE_DEPTH(DEPTH)) u_bsad_accum (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_addend  (in_addend),
        .in_acc_en  (in_acc_en),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input logic en);
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            int x = int'(a[8*i +: 8]);
            int y = int'(b[8*i +: 8]);
            s += (x > y) ? (x - y) : (y - x);
        end
        return en ? (c + 32'(s)) : 32'(s);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (ready_mode == 0)      out_ready = 1'b1;
        else if (ready_mode == 1) out_ready = ((cyc % 5) != 3) && ((cyc % 7) != 2);
        else                      out_ready = 1'b0;
    end

    // Output monitor and hold checker
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (hold_v) begin
                chk("R7 held valid", {31'b0, out_valid}, 32'd1);
                chk("R7 held data", out_result, hold_d);
            end
            hold_v = out_valid && !out_ready;
            hold_d = out_result;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected output", out_result, 32'hxxxx_xxxx);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, out_result, e);
                end
            end
        end
    end

    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic en, input string tag);
        bit done = 0;
        @(negedge clk);
        in_valid  = 1'b1;
        in_a      = a;
        in_b      = b;
        in_addend = c;
        in_acc_en = en;
        while (!done) begin
            #1;
            if (in_ready) begin
                exp_q.push_back(model(a, b, c, en));
                tag_q.push_back(tag);
                done = 1;
            end
            @(posedge clk);
            if (!done) @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R9
        chk("R9 out_valid after reset", {31'b0, out_valid}, 32'd0);
        chk("R9 in_ready after reset", {31'b0, in_ready}, 32'd1);

        // R2 / R3 / R4 / R5 directed values
        send(32'h87858381, 32'h08060402, 32'h00008000, 1'b0, "R2 example sum");
        send(32'h87858381, 32'h08060402, 32'h00008000, 1'b1, "R3 addend example");
        send(32'h87858381, 32'h08060402, 32'hFFFFFFFF, 1'b0, "R4 addend ignored");
        send(32'h87858381, 32'h08060402, 32'hFFFFFFFF, 1'b1, "R5 wrap");
        send(32'hFFFFFFFF, 32'h00000000, 32'h00000000, 1'b0, "R2 maximum");
        send(32'h00000000, 32'hFFFFFFFF, 32'hABCD0000, 1'b0, "R1 reversed maximum");
        send(32'h5A5A5A5A, 32'h5A5A5A5A, 32'h00000000, 1'b0, "R1 equal bytes");
        send(32'h00000000, 32'hFFFFFFFF, 32'hFFFFFC05, 1'b1, "R5 wrap to one");
        drain();

        // R6 latency
        send(32'h01020304, 32'h04030201, 32'h00000000, 1'b0, "R6 latency value");
        for (int k = 0; k < DEPTH - 1; k++) begin
            @(negedge clk); #2;
            chk("R6 not yet valid", {31'b0, out_valid}, 32'd0);
        end
        @(negedge clk); #2;
        chk("R6 valid after depth", {31'b0, out_valid}, 32'd1);
        drain();

        // R8 full stall
        @(posedge clk); #1 ready_mode = 2;
        send(32'h11223344, 32'h44332211, 32'h00000010, 1'b1, "R7 stalled first");
        send(32'hFF00FF00, 32'h00FF00FF, 32'h00000000, 1'b0, "R7 stalled second");
        @(negedge clk);
        in_valid  = 1'b1;
        in_a      = 32'hDEADBEEF;
        in_b      = 32'h01234567;
        in_addend = 32'h0;
        in_acc_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk("R8 in_ready low when full", {31'b0, in_ready}, 32'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(posedge clk); #1 ready_mode = 0;
        send(32'hDEADBEEF, 32'h01234567, 32'h0, 1'b0, "R7 third after release");
        drain();

        // R1 sweep of every byte value in every lane, irregular back-pressure
        @(posedge clk); #1 ready_mode = 1;
        for (int lane = 0; lane < 4; lane++) begin
            for (int x = 0; x < 256; x++) begin
                for (int yi = 0; yi < 7; yi++) begin
                    logic [7:0]  y;
                    logic [31:0] a;
                    logic [31:0] b;
                    logic [31:0] c;
                    case (yi)
                        0: y = 8'd0;   1: y = 8'd1;   2: y = 8'd51;
                        3: y = 8'd127; 4: y = 8'd128; 5: y = 8'd254;
                        default: y = 8'd255;
                    endcase
                    a = 32'h3C96A50F;
                    b = 32'hC3695AF0;
                    a[8*lane +: 8] = 8'(x);
                    b[8*lane +: 8] = y;
                    c = {8'(x), y, ~8'(x), y};
                    send(a, b, c, 1'(x), "R1 lane sweep");
                end
            end
        end
        drain();
        @(posedge clk); #1 ready_mode = 0;
        repeat (2) @(negedge clk);

        chk("R7 nothing left undelivered", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule